// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a hardware master for the two-wire Ethernet PHY management interface. One wire is the MDC clock and the other is the bidirectional MDIO data line. A client raises `req` for one clock and supplies three things: the operation (read or write), a 5-bit PHY address and a 5-bit register address. A write also takes 16 bits of data. The master then sends the whole serial frame on the pads. MDC comes from the system clock through a divider set by a parameter. Each MDC half period lasts `HALF_DIV` system clocks, which is about 1 µs at the default setting on a 100 MHz clock.

Every frame has the same layout:
- an extended all-ones preamble of 40 MDC cycles;
- a start pattern;
- an opcode;
- the two addresses.

A write then drives a two-bit turnaround and shifts out its data. A read releases MDIO for a single turnaround cycle and then samples 16 bits returned by the PHY. Both operations end with one extra MDC cycle in which MDIO is released. Completion is signalled by a one-cycle `done`. After a read, the collected word is held on `rd_data`.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc and mdio_oe are low, busy and done are low and rd_data is zero.
- R2: A request taken while busy is low sets busy on the next clock edge. A request raised while busy is high is ignored: it changes neither the frame in progress nor the outcome, and it leaves no transaction queued afterwards.
- R3: While a frame runs, every MDC low phase and every MDC high phase lasts exactly HALF_DIV system clocks. The first MDC rising edge comes HALF_DIV clocks after the request is accepted.
- R4: Each frame begins with 40 MDC periods in which MDIO is driven to 1.
- R5: Next the master drives the start bits 0 then 1. It then drives the opcode: 1,0 for a read (req_read=1) or 0,1 for a write (req_read=0).
- R6: Next come the PHY address and then the register address, 5 bits each, most significant bit first.
- R7: For a write, the master drives the turnaround bits 1 then 0, followed by the 16 data bits MSB first. Every driven bit changes only on an MDC falling edge, so it is stable at the following rising edge.
- R8: For a read, MDIO is released for one turnaround period and then for 16 data periods. The bit returned in each data period is sampled at the MDC falling edge that ends that period. The first sampled bit becomes rd_data[15].
- R9: After the last data bit, MDIO stays released for one more MDC period, so a read lasts 72 MDC periods and a write lasts 73. done is high for exactly one cycle, 2·HALF_DIV·periods system clocks after acceptance, and busy falls in that same cycle.
- R10: rd_data changes only at the completion of a read. A write leaves it unchanged.
- R11: Whenever busy is low, mdio_oe and mdc are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a transaction; taken only while busy is low |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read, held until the next read completes |
| mdc | output | 1 | Management clock pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO pad input |

## Verification
Busy is due one edge after the edge that accepts the request. The first MDC rise is due HALF_DIV edges after acceptance. Done, the fall of busy and a new rd_data value are all due at the edge 2·HALF_DIV·L after acceptance, where L is 72 or 73 MDC periods.

The bench drives inputs on falling clock edges and reads outputs on falling edges. It counts edges from acceptance and compares the count at which done appears against that formula. It captures the pad state at every MDC rising edge and times every MDC transition in system clocks, so frame content and half-period length are checked in the MDC domain. The read model changes mdio_i only on MDC rising edges, one half period before the falling edge at which the master samples.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

  localparam int unsigned PRE_LEN = 40;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned DATA_W  = 16;

  localparam int unsigned SOF_OFS = PRE_LEN;
  localparam int unsigned OPC_OFS = SOF_OFS + 2;
  localparam int unsigned PHY_OFS = OPC_OFS + 2;
  localparam int unsigned REG_OFS = PHY_OFS + ADDR_W;
  localparam int unsigned TA_OFS  = REG_OFS + ADDR_W;
  localparam int unsigned RD_TA   = 1;
  localparam int unsigned WR_TA   = 2;
  localparam int unsigned RD_LEN  = TA_OFS + RD_TA + DATA_W + 1;
  localparam int unsigned WR_LEN  = TA_OFS + WR_TA + DATA_W + 1;
  localparam int unsigned IDX_W   = $clog2(WR_LEN);

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e            op;
    logic [ADDR_W-1:0]   phy;
    logic [ADDR_W-1:0]   regad;
    logic [DATA_W-1:0]   wdata;
  } mdio_cmd_t;

  typedef enum logic [2:0] {
    SEG_PRE, SEG_SOF, SEG_OPC, SEG_PHY, SEG_REG, SEG_TA, SEG_DATA, SEG_IDLE
  } seg_e;

  // Number of MDC periods in a frame of the given kind.
  function automatic logic [IDX_W-1:0] frame_len(mdio_op_e op);
    return (op == OP_READ) ? IDX_W'(RD_LEN) : IDX_W'(WR_LEN);
  endfunction

  function automatic int unsigned ta_len(mdio_op_e op);
    return (op == OP_READ) ? RD_TA : WR_TA;
  endfunction

  function automatic int unsigned data_ofs(mdio_op_e op);
    return TA_OFS + ta_len(op);
  endfunction

  // Which field a given period index falls in.
  function automatic seg_e seg_of(mdio_op_e op, logic [IDX_W-1:0] idx);
    int unsigned i;
    i = idx;
    if (i < SOF_OFS)                 return SEG_PRE;
    if (i < OPC_OFS)                 return SEG_SOF;
    if (i < PHY_OFS)                 return SEG_OPC;
    if (i < REG_OFS)                 return SEG_PHY;
    if (i < TA_OFS)                  return SEG_REG;
    if (i < data_ofs(op))            return SEG_TA;
    if (i < data_ofs(op) + DATA_W)   return SEG_DATA;
    return SEG_IDLE;
  endfunction

  // Bit k of a width-bit field, counting from its MSB.
  function automatic logic msb_pick(logic [DATA_W-1:0] v, int unsigned width,
                                    int unsigned k);
    logic [DATA_W-1:0] t;
    t = v >> (width - 1 - k);
    return t[0];
  endfunction

  // {enable, value} driven on MDIO during period idx.
  function automatic logic [1:0] drive_of(mdio_cmd_t c, logic [IDX_W-1:0] idx);
    int unsigned i;
    logic        rd;
    i  = idx;
    rd = (c.op == OP_READ);
    case (seg_of(c.op, idx))
      SEG_PRE:  return 2'b11;
      SEG_SOF:  return {1'b1, (i == SOF_OFS + 1)};
      SEG_OPC:  return {1'b1, (i == OPC_OFS) ? rd : !rd};
      SEG_PHY:  return {1'b1, msb_pick(DATA_W'(c.phy), ADDR_W, i - PHY_OFS)};
      SEG_REG:  return {1'b1, msb_pick(DATA_W'(c.regad), ADDR_W, i - REG_OFS)};
      SEG_TA:   return rd ? 2'b01 : {1'b1, (i == TA_OFS)};
      SEG_DATA: return rd ? 2'b01
                          : {1'b1, msb_pick(c.wdata, DATA_W, i - data_ofs(c.op))};
      default:  return 2'b01;
    endcase
  endfunction

  // True in periods whose returned bit is collected.
  function automatic logic sample_slot(mdio_op_e op, logic [IDX_W-1:0] idx);
    return (op == OP_READ) && (seg_of(op, idx) == SEG_DATA);
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic half_end,
  output logic bit_end
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt;
  logic             mdc_q;

  assign half_end = run && (cnt == CNT_W'(HALF_DIV - 1));
  assign bit_end  = half_end && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (half_end) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_master_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  mdio_cmd_t req_cmd,
  input  logic      bit_end,
  output logic      run,
  output logic      accept,
  output mdio_op_e  op,
  output logic      mdio_o,
  output logic      mdio_oe,
  output logic      sample_stb,
  output logic      fin
);
  mdio_cmd_t        cmd_q;
  logic [IDX_W-1:0] idx;
  logic             run_q;
  logic [1:0]       drv;
  logic             last_bit;

  assign accept     = req && !run_q;
  assign run        = run_q;
  assign op         = cmd_q.op;
  assign drv        = drive_of(cmd_q, idx);
  assign mdio_oe    = run_q && drv[1];
  assign mdio_o     = run_q ? drv[0] : 1'b1;
  assign last_bit   = (idx == frame_len(cmd_q.op) - 1'b1);
  assign sample_stb = bit_end && sample_slot(cmd_q.op, idx);
  assign fin        = bit_end && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      idx   <= '0;
      run_q <= 1'b0;
    end else if (accept) begin
      cmd_q <= req_cmd;
      idx   <= '0;
      run_q <= 1'b1;
    end else if (bit_end) begin
      if (last_bit) begin
        run_q <= 1'b0;
        idx   <= '0;
      end else begin
        idx   <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_stb,
  input  logic          fin,
  input  logic          is_read,
  input  logic          mdio_i,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      rd_data <= '0;
    end else begin
      if (sample_stb) sh <= {sh[DW-2:0], mdio_i};
      if (fin && is_read) rd_data <= sh;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int unsigned HALF_DIV = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mdio_cmd_t cmd_in;
  mdio_op_e  op_w;
  logic      run_w, accept_w, half_end_w, bit_end_w, sample_stb_w, fin_w;

  assign cmd_in.op    = req_read ? OP_READ : OP_WRITE;
  assign cmd_in.phy   = req_phy;
  assign cmd_in.regad = req_reg;
  assign cmd_in.wdata = req_wdata;
  assign busy         = run_w;

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(run_w),
    .mdc(mdc), .half_end(half_end_w), .bit_end(bit_end_w)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_cmd(cmd_in),
    .bit_end(bit_end_w), .run(run_w), .accept(accept_w), .op(op_w),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .sample_stb(sample_stb_w), .fin(fin_w)
  );

  mdio_rx_shift #(.DW(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb_w), .fin(fin_w),
    .is_read(op_w == OP_READ), .mdio_i(mdio_i), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= fin_w;
  end

  logic unused_half;
  assign unused_half = half_end_w;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned HALF_DIV = 100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        sample_stb,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_data
);
  logic        mdc_q;
  logic [31:0] gap;

  // Clocks since the last MDC transition (or since acceptance).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      gap   <= '0;
    end else begin
      mdc_q <= mdc;
      if (accept)            gap <= 32'd0;
      else if (mdc != mdc_q) gap <= 32'd1;
      else if (gap != '1)    gap <= gap + 32'd1;
    end
  end

  p_half_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_q) |-> (gap == HALF_DIV));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_setup_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_sample_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!mdio_oe && mdc));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_data));

  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept_w), .sample_stb(sample_stb_w),
  .busy(busy), .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .rd_data(rd_data)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 3;
  localparam int WATCHDOG   = 150000;

  // {read, phy, reg, wdata, data returned by the PHY model}
  localparam logic [42:0] TBL [0:5] = '{
    {1'b0, 5'h01, 5'h00, 16'h1234, 16'h0000},
    {1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3},
    {1'b0, 5'h10, 5'h01, 16'hFFFF, 16'h0000},
    {1'b1, 5'h00, 5'h00, 16'h0000, 16'h0001},
    {1'b0, 5'h15, 5'h0A, 16'h0000, 16'h0000},
    {1'b1, 5'h0A, 5'h15, 16'h0000, 16'h8000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_read = 1'b0;
  logic [4:0]  req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  int errors = 0, checks = 0;
  int tcyc = 0, last_edge = 0, hp_bad = 0;
  int nb = 0, pre_bad = 0, sof_bad = 0, adr_bad = 0, tail_bad = 0, idle_bad = 0;
  bit cap_on = 0;
  logic        cur_rd;
  logic [4:0]  cur_phy, cur_rg;
  logic [15:0] cur_wd, cur_rdat, prev_rd = 16'h0000;

  mdio_master #(.HALF_DIV(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_read(req_read),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    tcyc = tcyc + 1;
    if (req && !busy && rst_n) last_edge = tcyc;
    if (tcyc > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", tcyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", what, act, exp);
    end
  endtask

  // Expected {enable, value} for period b, built from whole-frame vectors.
  function automatic logic [1:0] exp_drive(logic rd, logic [4:0] p, logic [4:0] r,
                                           logic [15:0] w, int b);
    logic [53:0] hdr;
    hdr = {{40{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), p, r};
    if (b < 54) return {1'b1, hdr[53-b]};
    if (rd)     return 2'b00;
    if (b == 54) return 2'b11;
    if (b == 55) return 2'b10;
    if (b <= 71) return {1'b1, w[71-b]};
    return 2'b00;
  endfunction

  // Pad capture at each MDC rise, and PHY model for reads.
  always @(posedge mdc) begin
    if (cap_on) begin
      logic [1:0] e;
      logic bad;
      e = exp_drive(cur_rd, cur_phy, cur_rg, cur_wd, nb);
      bad = (e[1] == 1'b0) ? (mdio_oe !== 1'b0)
                           : (mdio_oe !== 1'b1 || mdio_o !== e[0]);
      if (bad) begin
        if (nb < 40)                          pre_bad++;
        else if (nb < 44)                     sof_bad++;
        else if (nb < 54)                     adr_bad++;
        else if (nb == (cur_rd ? 71 : 72))    idle_bad++;
        else                                  tail_bad++;
      end
      if (cur_rd && nb >= 55 && nb <= 70) mdio_i = cur_rdat[70-nb];
      else                                mdio_i = 1'b1;
      nb++;
    end
  end

  always @(mdc) begin
    if (cap_on) begin
      if (tcyc - last_edge != H) hp_bad++;
      last_edge = tcyc;
    end
  end

  task automatic run_txn(input logic [42:0] v, input bit poke);
    int cyc, len;
    {cur_rd, cur_phy, cur_rg, cur_wd, cur_rdat} = v;
    len = cur_rd ? 72 : 73;
    nb = 0; pre_bad = 0; sof_bad = 0; adr_bad = 0; tail_bad = 0; idle_bad = 0;
    hp_bad = 0; cap_on = 1;
    @(negedge clk);
    req = 1'b1; req_read = cur_rd; req_phy = cur_phy; req_reg = cur_rg;
    req_wdata = cur_wd;
    cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == 1) begin
        req = 1'b0;
        check("R2 busy after accept", busy, 1);
      end
      if (poke && cyc == 40) begin
        req = 1'b1; req_read = ~cur_rd; req_phy = ~cur_phy; req_reg = ~cur_rg;
        req_wdata = ~cur_wd;
      end
      if (poke && cyc == 41) begin
        req = 1'b0;
        check("R2 busy kept during ignored request", busy, 1);
      end
      if (done || cyc > 4000) break;
    end
    cap_on = 0;
    check("R9 done timing", cyc, 2*H*len + 1);
    check("R9 busy low with done", busy, 0);
    check("R9 frame length", nb, len);
    check("R3 half periods", hp_bad, 0);
    check("R4 preamble", pre_bad, 0);
    check("R5 start and opcode", sof_bad, 0);
    check("R6 addresses", adr_bad, 0);
    check(cur_rd ? "R8 read release" : "R7 write turnaround and data", tail_bad, 0);
    check("R9 trailing released period", idle_bad, 0);
    if (cur_rd) begin
      check("R8 read data", rd_data, cur_rdat);
      prev_rd = cur_rdat;
    end else begin
      check("R10 rd_data kept over write", rd_data, prev_rd);
    end
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    check("R11 idle release", {mdc, mdio_oe}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset pads", {mdc, mdio_oe}, 2'b00);
    check("R1 reset busy/done", {busy, done}, 2'b00);
    check("R1 reset rd_data", rd_data, 16'h0000);

    for (int i = 0; i < 6; i++) run_txn(TBL[i], 1'b0);

    // Requests raised mid-frame are dropped: no second transaction follows.
    run_txn({1'b1, 5'h11, 5'h02, 16'h0000, 16'h5A0F}, 1'b1);
    run_txn({1'b0, 5'h03, 5'h1C, 16'hC3A5, 16'h0000}, 1'b1);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 4*H*80; k++) begin
        @(negedge clk);
        if (busy || done || mdc || mdio_oe) seen++;
      end
      check("R2 no queued request", seen, 0);
      check("R10 rd_data held while idle", rd_data, 16'h5A0F);
    end

    summary();
    $finish;
  end
endmodule